// File: doc/BRIEF.md
# Multi-Mode Edge Input Capture Unit

This block timestamps activity on an external input pin. The pin is first brought into the clock domain through a synchronizer chain. Rising and falling transitions are then detected, and a mode select decides which of them count as capture events. On every capture event the value of a free-running time base input is written into a four-entry buffer. The time base can be kept at full width or cut down to its low half. An event counter raises a one-cycle interrupt pulse after a programmable number of capture events.

Captured values leave the block as a valid/ready stream. `cap_valid` is high while the buffer holds at least one entry, and `cap_data` always shows the oldest entry. An entry is consumed on each rising clock edge where both `cap_valid` and `cap_ready` are high. Holding `cap_ready` low is allowed at any time. The buffer then fills, and once it is full further captures are dropped and recorded in a sticky overflow flag. A capture and a read on the same edge into a full buffer do not count as an overflow. Mode, width select, event-count select and enable are plain level controls.

Top module: `edge_capture_unit`

## Requirements
- R1: Mode code 4'b0001 makes every rising transition of the synchronized pin a capture event. Falling transitions are ignored.
- R2: Mode code 4'b0010 makes every falling transition a capture event. Rising transitions are ignored.
- R3: Mode codes 4'b0000 and 4'b0011 both make every rising and every falling transition a capture event.
- R4: Mode code 4'b0100 makes every fourth rising transition a capture event. Mode code 4'b0101 makes every sixteenth rising transition a capture event.
- R5: Mode codes 4'b0110, 4'b0111 and any code with bit 3 set produce no capture events and no interrupts.
- R6: With event-count select N in 0..3, `irq` is high for exactly one cycle after every N+1 capture events. It rises on the same clock edge that writes the (N+1)-th entry.
- R7: With N above 3, the interrupt still fires after N+1 events. If nothing is read, the fifth event finds the buffer full, so the overflow flag is set before the interrupt.
- R8: With `wide` = 1 the full 32-bit time base is stored. With `wide` = 0 only bits 15:0 are stored and bits 31:16 of the entry read as zero.
- R9: The buffer holds four entries in arrival order. A capture into a full buffer with no read on that edge is discarded and sets `overflow`, which stays set until reset.
- R10: A pin change present before clock edge k is captured on edge k+2. The stored value is the time base present at that edge.
- R11: The four/sixteen edge divider restarts from zero whenever the mode code changes or `enable` is low. While `enable` is low there are no capture events and the event counter is cleared.
- R12: After reset `cap_valid`, `overflow` and `irq` are low. `cap_data` shows the oldest entry. When a capture and a read fall on the same edge while the buffer is full, the oldest entry is removed, the new one is stored, and `overflow` is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Module enable; low clears the divider and event counter |
| cap_pin | input | 1 | Asynchronous capture input pin |
| timebase | input | 32 | Free-running time base value |
| mode | input | 4 | Capture mode code |
| wide | input | 1 | 1: store 32-bit time base, 0: store low 16 bits |
| evt_sel | input | 4 | Interrupt after evt_sel+1 capture events |
| cap_data | output | 32 | Oldest buffered capture value |
| cap_valid | output | 1 | Buffer not empty |
| cap_ready | input | 1 | Consumer accepts the head entry |
| overflow | output | 1 | Sticky flag: a capture was dropped |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The case that matters most is a capture event and a buffer read falling on the same clock edge while the buffer holds four entries. The bench fills the buffer with four distinct timestamps. It then starts a fifth pin edge and raises `cap_ready` for exactly the edge on which that capture is written. It judges the result by `overflow` staying low and by draining the buffer: the three surviving old entries must come out in order, followed by the new timestamp. The interrupt pulse and the buffer write also share an edge. That is checked by sampling `irq` and `cap_valid` together in the cycle after the write.

// File: rtl/ecu_pkg.sv
package ecu_pkg;
  localparam logic [3:0] MODE_ANY_A  = 4'b0000;
  localparam logic [3:0] MODE_RISE   = 4'b0001;
  localparam logic [3:0] MODE_FALL   = 4'b0010;
  localparam logic [3:0] MODE_ANY_B  = 4'b0011;
  localparam logic [3:0] MODE_DIV_LO = 4'b0100;
  localparam logic [3:0] MODE_DIV_HI = 4'b0101;

  function automatic logic mode_reserved(input logic [3:0] m);
    return m[3] || (m == 4'b0110) || (m == 4'b0111);
  endfunction

  function automatic logic mode_divides(input logic [3:0] m);
    return (m == MODE_DIV_LO) || (m == MODE_DIV_HI);
  endfunction
endpackage

// File: rtl/ecu_pin_sync.sv
module ecu_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain;
  logic              lvl;
  logic              last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
      last  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], pin_i};
      last  <= chain[STAGES-1];
    end
  end

  assign lvl    = chain[STAGES-1];
  assign rise_o = lvl & ~last;
  assign fall_o = ~lvl & last;

  generate
    if (STAGES == 2) begin : g_chk
      p_rise_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |-> $past(pin_i, 2));
      p_fall_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |-> !$past(pin_i, 2));
    end
  endgenerate
endmodule

// File: rtl/ecu_event_sel.sv
module ecu_event_sel
  import ecu_pkg::*;
#(
  parameter int DIV_FAST = 4,
  parameter int DIV_SLOW = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic [3:0] mode_i,
  input  logic       rise_i,
  input  logic       fall_i,
  output logic       evt_o
);
  localparam int DW = $clog2(DIV_SLOW);

  logic [3:0]    mode_q;
  logic [DW-1:0] div_cnt;
  logic [DW-1:0] div_lim;
  logic          mode_chg;
  logic          div_hit;

  assign mode_chg = (mode_i != mode_q);
  assign div_lim  = (mode_i == MODE_DIV_HI) ? DW'(DIV_SLOW - 1) : DW'(DIV_FAST - 1);
  assign div_hit  = rise_i && (div_cnt == div_lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      div_cnt <= '0;
    end else begin
      mode_q <= mode_i;
      if (!en_i || mode_chg || !mode_divides(mode_i))
        div_cnt <= '0;
      else if (rise_i)
        div_cnt <= div_hit ? '0 : div_cnt + 1'b1;
    end
  end

  always_comb begin
    evt_o = 1'b0;
    if (en_i && !mode_chg) begin
      case (mode_i)
        MODE_ANY_A, MODE_ANY_B:   evt_o = rise_i | fall_i;
        MODE_RISE:                evt_o = rise_i;
        MODE_FALL:                evt_o = fall_i;
        MODE_DIV_LO, MODE_DIV_HI: evt_o = div_hit;
        default:                  evt_o = 1'b0;
      endcase
    end
  end

  p_reserved_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mode_reserved(mode_i) |-> !evt_o);
  p_divide_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_divides(mode_i) && evt_o) |-> rise_i);
  p_div_cleared_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (div_cnt == '0));
endmodule

// File: rtl/ecu_fifo.sv
module ecu_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] push_data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         valid_o,
  output logic         overflow_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          full, do_pop, do_push;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt == CW'(DEPTH));
  assign valid_o = (cnt != '0);
  assign do_pop  = pop_i && valid_o;
  assign do_push = push_i && (!full || do_pop);
  assign head_o  = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp         <= '0;
      rp         <= '0;
      cnt        <= '0;
      overflow_o <= 1'b0;
    end else begin
      if (do_push) wp <= bump(wp);
      if (do_pop)  rp <= bump(rp);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
      if (push_i && !do_push) overflow_o <= 1'b1;
    end
  end

  p_count_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  p_drop_when_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && full && !pop_i) |=> (full && overflow_o));
  p_overflow_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |=> overflow_o);
  p_swap_keeps_full_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && full && pop_i && !overflow_o) |=> (full && !overflow_o));
endmodule

// File: rtl/ecu_irq_count.sv
module ecu_irq_count #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          evt_i,
  input  logic [CW-1:0] thr_i,
  output logic          irq_o
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      irq_o <= 1'b0;
    end else if (!en_i) begin
      cnt   <= '0;
      irq_o <= 1'b0;
    end else begin
      irq_o <= 1'b0;
      if (evt_i) begin
        if (cnt >= thr_i) begin
          cnt   <= '0;
          irq_o <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  p_irq_from_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(evt_i));
  p_irq_silent_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !irq_o);
endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit #(
  parameter int TW          = 32,
  parameter int NW          = 16,
  parameter int DEPTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          cap_pin,
  input  logic [TW-1:0] timebase,
  input  logic [3:0]    mode,
  input  logic          wide,
  input  logic [3:0]    evt_sel,
  output logic [TW-1:0] cap_data,
  output logic          cap_valid,
  input  logic          cap_ready,
  output logic          overflow,
  output logic          irq
);
  logic          rise, fall, evt;
  logic [TW-1:0] stamp;

  assign stamp = wide ? timebase : {{(TW-NW){1'b0}}, timebase[NW-1:0]};

  ecu_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(cap_pin), .rise_o(rise), .fall_o(fall)
  );

  ecu_event_sel u_sel (
    .clk(clk), .rst_n(rst_n), .en_i(enable), .mode_i(mode),
    .rise_i(rise), .fall_i(fall), .evt_o(evt)
  );

  ecu_fifo #(.W(TW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push_i(evt), .push_data_i(stamp),
    .pop_i(cap_ready), .head_o(cap_data), .valid_o(cap_valid),
    .overflow_o(overflow)
  );

  ecu_irq_count #(.CW(4)) u_irq (
    .clk(clk), .rst_n(rst_n), .en_i(enable), .evt_i(evt),
    .thr_i(evt_sel), .irq_o(irq)
  );

  p_irq_with_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cap_valid || overflow));
endmodule

// File: tb/test_edge_capture_unit.sv
module test_edge_capture_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 15;
  // fields: mode, pulses, evt_sel, exp captures, exp irqs, exp overflow
  localparam int VEC [NV][6] = '{
    '{1,  3, 0, 3, 3, 0},  // R1
    '{2,  3, 2, 3, 1, 0},  // R2
    '{0,  2, 1, 4, 2, 0},  // R3
    '{3,  2, 3, 4, 1, 0},  // R3
    '{4,  8, 1, 2, 1, 0},  // R4
    '{4,  7, 0, 1, 1, 0},  // R4
    '{5, 16, 0, 1, 1, 0},  // R4
    '{5, 15, 0, 0, 0, 0},  // R4
    '{6,  4, 0, 0, 0, 0},  // R5
    '{7,  4, 0, 0, 0, 0},  // R5
    '{8,  4, 0, 0, 0, 0},  // R5
    '{15, 4, 0, 0, 0, 0},  // R5
    '{1,  6, 0, 4, 6, 1},  // R9
    '{1,  5, 4, 4, 1, 1},  // R7
    '{1,  4, 4, 4, 0, 0}   // R7
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b1;
  logic        cap_pin = 1'b0;
  logic [31:0] timebase;
  logic [3:0]  mode = 4'd1;
  logic        wide = 1'b1;
  logic [3:0]  evt_sel = 4'd0;
  logic [31:0] cap_data;
  logic        cap_valid;
  logic        cap_ready = 1'b0;
  logic        overflow;
  logic        irq;

  logic        use_ramp = 1'b0;
  logic [31:0] ramp = '0;
  logic [31:0] tb_fixed = 32'h0;
  int          irq_seen;
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign timebase = use_ramp ? ramp : tb_fixed;

  always @(negedge clk) begin
    ramp <= ramp + 1;
    if (!rst_n) irq_seen = 0;
    else if (irq) irq_seen = irq_seen + 1;
  end

  edge_capture_unit i_edge_capture_unit (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cap_pin(cap_pin),
    .timebase(timebase), .mode(mode), .wide(wide), .evt_sel(evt_sel),
    .cap_data(cap_data), .cap_valid(cap_valid), .cap_ready(cap_ready),
    .overflow(overflow), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse();
    @(negedge clk); cap_pin = 1'b1;
    repeat (3) @(negedge clk);
    cap_pin = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic pop_one(output logic [31:0] d, output logic ok);
    ok = cap_valid;
    d = cap_data;
    cap_ready = 1'b1;
    @(negedge clk);
    cap_ready = 1'b0;
  endtask

  task automatic drain(output int n);
    logic [31:0] d;
    logic ok;
    n = 0;
    for (int i = 0; i < 8; i++) begin
      if (cap_valid) begin
        pop_one(d, ok);
        n++;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, n0;
    logic ok;
    int n;

    // R12: reset state
    do_reset();
    check("R12 valid after reset", {31'b0, cap_valid}, 32'd0);
    check("R12 overflow after reset", {31'b0, overflow}, 32'd0);
    check("R12 irq after reset", {31'b0, irq}, 32'd0);

    // vector table walk
    for (int v = 0; v < NV; v++) begin
      mode = 4'(VEC[v][0]);
      evt_sel = 4'(VEC[v][2]);
      wide = 1'b1;
      tb_fixed = 32'h1000 + v;
      do_reset();
      for (int p = 0; p < VEC[v][1]; p++) pulse();
      repeat (4) @(negedge clk);
      check($sformatf("vec%0d irq count", v), irq_seen, VEC[v][4]);
      check($sformatf("vec%0d overflow", v), {31'b0, overflow}, VEC[v][5]);
      drain(n);
      check($sformatf("vec%0d captures", v), n, VEC[v][3]);
    end

    // R10, R6: latency, timestamp, irq in same cycle as write
    mode = 4'd1; evt_sel = 4'd0; wide = 1'b1; use_ramp = 1'b1;
    do_reset();
    @(negedge clk); #1; n0 = ramp; cap_pin = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R10 no capture before third edge", {31'b0, cap_valid}, 32'd0);
    @(negedge clk);
    check("R10 capture on third edge", {31'b0, cap_valid}, 32'd1);
    check("R6 irq with write", {31'b0, irq}, 32'd1);
    check("R10 timestamp", cap_data, n0 + 32'd2);
    @(negedge clk);
    check("R6 irq single cycle", {31'b0, irq}, 32'd0);
    cap_pin = 1'b0;
    drain(n);
    use_ramp = 1'b0;

    // R8: width select
    tb_fixed = 32'hDEAD_BEEF; wide = 1'b0;
    pulse(); repeat (4) @(negedge clk);
    pop_one(d, ok);
    check("R8 narrow stamp", d, 32'h0000_BEEF);
    wide = 1'b1;
    pulse(); repeat (4) @(negedge clk);
    pop_one(d, ok);
    check("R8 wide stamp", d, 32'hDEAD_BEEF);

    // R11: divider restart on mode change
    mode = 4'd4; do_reset();
    repeat (3) pulse();
    mode = 4'd5; repeat (2) @(negedge clk); mode = 4'd4; repeat (2) @(negedge clk);
    pulse(); repeat (4) @(negedge clk);
    check("R11 mode change restarts divider", {31'b0, cap_valid}, 32'd0);
    repeat (3) pulse(); repeat (4) @(negedge clk);
    check("R11 fourth edge after restart", {31'b0, cap_valid}, 32'd1);
    drain(n);
    // R11: divider restart on disable
    repeat (3) pulse();
    enable = 1'b0; repeat (2) @(negedge clk); enable = 1'b1;
    pulse(); repeat (4) @(negedge clk);
    check("R11 disable restarts divider", {31'b0, cap_valid}, 32'd0);
    enable = 1'b0; pulse(); repeat (4) @(negedge clk);
    check("R11 no capture when disabled", {31'b0, cap_valid}, 32'd0);
    enable = 1'b1;

    // R12: capture and read on the same edge with a full buffer
    mode = 4'd1; evt_sel = 4'd3; do_reset();
    for (int k = 0; k < 4; k++) begin
      tb_fixed = 32'd100 + k;
      pulse();
    end
    repeat (4) @(negedge clk);
    check("R9 full no overflow", {31'b0, overflow}, 32'd0);
    tb_fixed = 32'd200;
    @(negedge clk); cap_pin = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R12 head before swap", cap_data, 32'd100);
    cap_ready = 1'b1;
    @(negedge clk);
    cap_ready = 1'b0;
    check("R12 no overflow on swap", {31'b0, overflow}, 32'd0);
    cap_pin = 1'b0;
    for (int k = 0; k < 4; k++) begin
      pop_one(d, ok);
      check($sformatf("R12 order entry %0d", k), d, (k < 3) ? 32'd101 + k : 32'd200);
    end
    check("R12 empty after drain", {31'b0, cap_valid}, 32'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule